// File: doc/BRIEF.md
# Bilinear Charge Digitizing Counter

This block forms the digital back end of one charge-integrating converter channel. The analog front end emits one short pulse for every 0.25 pC of integrated charge while the held charge runs down. The block counts those pulses into an 8-bit conversion code. A conversion begins with a start request, which also captures a 3-bit gain mode. Quantum pulses are counted while the conversion runs. An end-of-rundown input closes the conversion and produces a one-cycle done strobe.

The five modes give five transfer curves. Two are linear: fine, where each pulse adds one count, and coarse, where one count is added for every four pulses. The other three are bilinear. They count at fine gain until the code reaches a breakpoint, then continue at coarse gain. The step from fine to coarse gain is exactly 1:4. The code saturates at its all-ones value, which flags an off-scale result.

The quantum, start, end-of-rundown and clear inputs are single-cycle control strobes. The pulse source is a physical process and cannot be stalled, so there is no back-pressure on any input. The code is a level that stays valid from the done strobe until the next clear or accepted start. It has no handshake, and a downstream reader may sample it at any time after done.

Top module: `qbc_top`

## Requirements
- R1: After reset, code_o is 0 and done_o and overflow_o are low.
- R2: The gain mode is taken from mode_i only in the cycle where a start is accepted. Code 0 is linear fine. Code 1 is linear coarse. Codes 2, 3 and 4 are bilinear with breakpoints at counts 32, 64 and 128. Codes 5 to 7 act as code 0. Changes to mode_i during a conversion have no effect.
- R3: In linear fine gain, every accepted quantum pulse adds one to the code.
- R4: In linear coarse gain, the code grows by one on every fourth accepted pulse. A partial group of fewer than four pulses at the end of a conversion adds nothing.
- R5: In a bilinear mode, each pulse adds one count while the code is below the breakpoint. Once the code equals the breakpoint, counting continues at one count per four pulses, with the four-pulse group starting empty.
- R6: The code saturates at 255 and holds there for any further pulses. overflow_o is high exactly while the code is 255.
- R7: Quantum pulses outside a running conversion do not change the code. This includes pulses in the cycle of the start itself.
- R8: rundown_end_i during a running conversion ends it. A quantum pulse in that same cycle is still counted. done_o is high for exactly the one following cycle, and the code then holds.
- R9: start_i while a conversion is running is ignored. Counting continues with the original mode.
- R10: clear_i returns code_o, done_o and overflow_o to zero on the next cycle and aborts any conversion. It takes priority over every other input in the same cycle.
- R11: A start accepted when no conversion is running zeroes the code on the next cycle and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion strobe |
| mode_i | input | 3 | Gain mode, captured at start |
| quantum_i | input | 1 | One charge quantum (0.25 pC) per high cycle |
| rundown_end_i | input | 1 | End of rundown, closes the conversion |
| clear_i | input | 1 | Synchronous clear and abort |
| code_o | output | 8 | Conversion code |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| overflow_o | output | 1 | Off-scale flag, high while the code is all ones |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a four-to-one coarse prescaler and breakpoints at 32, 64 and 128. With these values, 255 fine pulses reach saturation in linear fine mode, and 1020 pulses reach it in coarse mode. Every breakpoint, plus or minus a partial prescaler group, lies within a conversion of about a thousand pulses. Directed cases sit on each breakpoint edge and on both sides of saturation. Random conversions cover all eight mode codes, with pulse gaps, mode changes during a conversion and starts while a conversion is running.

// File: rtl/qbc_pkg.sv
package qbc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    QM_FINE   = 3'd0,
    QM_COARSE = 3'd1,
    QM_BL_LO  = 3'd2,
    QM_BL_MID = 3'd3,
    QM_BL_HI  = 3'd4
  } qm_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } st_e;
endpackage

// File: rtl/qbc_gain_sel.sv
module qbc_gain_sel
  import qbc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int BP_LO  = 32,
  parameter int BP_MID = 64,
  parameter int BP_HI  = 128
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CODE_W-1:0] count_i,
  output logic              fine_o
);
  always_comb begin
    case (mode_i)
      QM_COARSE: fine_o = 1'b0;
      QM_BL_LO:  fine_o = (count_i < CODE_W'(BP_LO));
      QM_BL_MID: fine_o = (count_i < CODE_W'(BP_MID));
      QM_BL_HI:  fine_o = (count_i < CODE_W'(BP_HI));
      default:   fine_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/qbc_prescaler.sv
module qbc_prescaler #(
  parameter int RATIO_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic pulse_i,
  input  logic fine_i,
  output logic step_o
);
  generate
    if (RATIO_LOG2 == 0) begin : g_direct
      assign step_o = pulse_i;
    end else begin : g_div
      logic [RATIO_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pre_q <= '0;
        else if (clr_i)              pre_q <= '0;
        else if (pulse_i && !fine_i) pre_q <= pre_q + 1'b1;
      end
      assign step_o = pulse_i && (fine_i || (pre_q == '1));
    end
  endgenerate
endmodule

// File: rtl/qbc_sat_counter.sv
module qbc_sat_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] count_o,
  output logic              at_max_o
);
  logic [CODE_W-1:0] cnt_q;

  assign at_max_o = (cnt_q == '1);
  assign count_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (step_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qbc_top.sv
module qbc_top
  import qbc_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int RATIO_LOG2 = 2,
  parameter int BP_LO      = 32,
  parameter int BP_MID     = 64,
  parameter int BP_HI      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic              quantum_i,
  input  logic              rundown_end_i,
  input  logic              clear_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              overflow_o
);
  st_e               st_q;
  logic [MODE_W-1:0] mode_q;
  logic              done_q;
  logic              busy;
  logic              start_ok;
  logic              clr_cnt;
  logic              pulse_en;
  logic              fine_now;
  logic              step;
  logic [CODE_W-1:0] count;
  logic              at_max;

  assign busy     = (st_q == ST_RUN);
  assign start_ok = start_i && !busy;
  assign clr_cnt  = clear_i || start_ok;
  assign pulse_en = quantum_i && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else if (start_ok) begin
      st_q   <= ST_RUN;
      mode_q <= mode_i;
      done_q <= 1'b0;
    end else if (busy && rundown_end_i) begin
      st_q   <= ST_HOLD;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  qbc_gain_sel #(
    .CODE_W(CODE_W), .BP_LO(BP_LO), .BP_MID(BP_MID), .BP_HI(BP_HI)
  ) u_gain (
    .mode_i (mode_q),
    .count_i(count),
    .fine_o (fine_now)
  );

  qbc_prescaler #(.RATIO_LOG2(RATIO_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_cnt),
    .pulse_i(pulse_en),
    .fine_i (fine_now),
    .step_o (step)
  );

  qbc_sat_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_cnt),
    .step_i  (step),
    .count_o (count),
    .at_max_o(at_max)
  );

  assign code_o     = count;
  assign done_o     = done_q;
  assign overflow_o = at_max;
endmodule

// File: rtl/qbc_checker.sv
module qbc_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              quantum_i,
  input logic              rundown_end_i,
  input logic              clear_i,
  input logic              busy,
  input logic [2:0]        mode_q,
  input logic [CODE_W-1:0] code_o,
  input logic              done_o,
  input logic              overflow_o
);
  localparam logic [CODE_W-1:0] FULL = '1;

  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (code_o == '0) && !done_o && !overflow_o);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clear_i && !start_i) |=> $stable(code_o));

  a_r6_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_o == FULL) && !clear_i && !start_i) |=> (code_o == FULL));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(rundown_end_i) && $past(busy)));

  a_r3_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && quantum_i && !clear_i && (mode_q == 3'd0) && (code_o != FULL))
      |=> (code_o == CODE_W'($past(code_o) + 1'b1)));

  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear_i)
      |=> ((code_o == $past(code_o)) || (code_o == CODE_W'($past(code_o) + 1'b1))));
endmodule

bind qbc_top qbc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .quantum_i    (quantum_i),
  .rundown_end_i(rundown_end_i),
  .clear_i      (clear_i),
  .busy         (busy),
  .mode_q       (mode_q),
  .code_o       (code_o),
  .done_o       (done_o),
  .overflow_o   (overflow_o)
);

// File: tb/sim_qbc_top.sv
`timescale 1ns/1ps
module sim_qbc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       quantum_i = 1'b0;
  logic       rundown_end_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [7:0] code_o;
  logic       done_o;
  logic       overflow_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  qbc_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .quantum_i(quantum_i), .rundown_end_i(rundown_end_i), .clear_i(clear_i),
    .code_o(code_o), .done_o(done_o), .overflow_o(overflow_o)
  );

  function automatic int exp_code(input int mode, input int n);
    int bp;
    int v;
    case (mode)
      1: bp = 0;
      2: bp = 32;
      3: bp = 64;
      4: bp = 128;
      default: bp = -1;
    endcase
    if (bp < 0)       v = n;
    else if (n <= bp) v = n;
    else              v = bp + (n - bp) / 4;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // One conversion: start with mode, n pulses, end of rundown; checks the result.
  task automatic run_conv(input int mode, input int n, input bit end_same,
                          input bit disturb, input string req);
    int e;
    e = exp_code(mode, n);
    start_i = 1'b1; mode_i = 3'(mode); quantum_i = 1'b1;  // pulse in start cycle is ignored (R7)
    @(negedge clk);
    start_i = 1'b0; quantum_i = 1'b0;
    check(code_o == 8'd0, "R11 start zeroes code", code_o, 0);
    for (int i = 0; i < n; i++) begin
      if (disturb) begin
        mode_i = 3'($urandom_range(0, 7));                     // R2: no effect mid-run
        start_i = ($urandom_range(0, 15) == 0);                // R9: ignored mid-run
        if ($urandom_range(0, 3) == 0) begin
          quantum_i = 1'b0;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
      quantum_i = 1'b1;
      if (end_same && i == n - 1) rundown_end_i = 1'b1;
      @(negedge clk);
      quantum_i = 1'b0; start_i = 1'b0; rundown_end_i = 1'b0;
    end
    if (!end_same || n == 0) begin
      rundown_end_i = 1'b1;
      @(negedge clk);
      rundown_end_i = 1'b0;
    end
    check(done_o == 1'b1, {req, " R8 done strobe"}, done_o, 1);
    check(code_o == 8'(e), {req, " code"}, code_o, e);
    check(overflow_o == (e == 255), {req, " R6 overflow flag"}, overflow_o, (e == 255));
    quantum_i = 1'b1;                                          // R7: ignored after done
    @(negedge clk);
    quantum_i = 1'b0;
    check(done_o == 1'b0, "R8 done lasts one cycle", done_o, 0);
    check(code_o == 8'(e), "R7 code held after done", code_o, e);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end

  initial begin
    int s;
    s = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check(code_o == 8'd0 && done_o == 1'b0 && overflow_o == 1'b0,
          "R1 reset state", {code_o, done_o, overflow_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (5) begin
      quantum_i = 1'b1; @(negedge clk); quantum_i = 1'b0;
    end
    check(code_o == 8'd0, "R7 idle pulses ignored", code_o, 0);

    run_conv(0, 40, 1'b0, 1'b0, "R3 fine 40");
    run_conv(0, 254, 1'b0, 1'b0, "R3 fine 254");
    run_conv(0, 255, 1'b0, 1'b0, "R6 fine 255");
    run_conv(0, 300, 1'b0, 1'b0, "R6 fine sat");
    run_conv(1, 3, 1'b0, 1'b0, "R4 coarse partial");
    run_conv(1, 4, 1'b0, 1'b0, "R4 coarse 4");
    run_conv(1, 1020, 1'b0, 1'b0, "R6 coarse full");
    run_conv(2, 32, 1'b0, 1'b0, "R5 bp32 edge");
    run_conv(2, 35, 1'b0, 1'b0, "R5 bp32 +3");
    run_conv(2, 36, 1'b0, 1'b0, "R5 bp32 +4");
    run_conv(3, 68, 1'b0, 1'b0, "R5 bp64 +4");
    run_conv(4, 635, 1'b0, 1'b0, "R5 bp128 254");
    run_conv(4, 636, 1'b0, 1'b0, "R6 bp128 255");
    run_conv(6, 10, 1'b0, 1'b0, "R2 mode6 as fine");
    run_conv(2, 50, 1'b1, 1'b0, "R8 pulse with end");
    run_conv(0, 0, 1'b0, 1'b0, "R8 empty");
    run_conv(3, 120, 1'b0, 1'b1, "R9 R2 disturbed");

    // R10: clear mid-conversion, with start in the same cycle
    start_i = 1'b1; mode_i = 3'd0; @(negedge clk); start_i = 1'b0;
    repeat (20) begin quantum_i = 1'b1; @(negedge clk); end
    quantum_i = 1'b1; clear_i = 1'b1; start_i = 1'b1; @(negedge clk);
    quantum_i = 1'b0; clear_i = 1'b0; start_i = 1'b0;
    check(code_o == 8'd0 && done_o == 1'b0, "R10 clear zeroes", code_o, 0);
    quantum_i = 1'b1; rundown_end_i = 1'b1; @(negedge clk);
    quantum_i = 1'b0; rundown_end_i = 1'b0;
    check(done_o == 1'b0 && code_o == 8'd0, "R10 clear aborts", {done_o, code_o}, 0);
    run_conv(0, 300, 1'b0, 1'b0, "R6 sat before clear");
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(overflow_o == 1'b0 && code_o == 8'd0, "R10 clear overflow", overflow_o, 0);

    for (int k = 0; k < 30; k++) begin
      int m;
      int n;
      m = $urandom_range(0, 7);
      n = $urandom_range(0, 1100);
      run_conv(m, n, ($urandom_range(0, 1) == 1), 1'b1, "R2 R5 random");
    end
    finish_run();
  end
endmodule